// File: doc/BRIEF.md
# Warp Instruction Buffer with Hazard Scoreboard

This block sits between the decode stage and the issue stage of a SIMT core. It holds a few decoded instructions for each warp in a small in-order queue. For every queued instruction it reports whether the instruction can be issued without a register hazard. Each decoded instruction carries a warp number, one destination register and a fixed number of source registers. Per warp, the block keeps a set of reserved destination registers. A register is added to that set when an instruction writing it issues, and removed when that instruction writes back. An instruction is held back while any register it names is in the set. This covers read-after-write and write-after-write hazards, and it still lets several independent instructions of one warp be in flight at once.

Decoded instructions enter through a valid/ready stream. A transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low when the target warp's queue is full or that warp is being flushed in the same cycle. The producer must then hold the instruction until `in_ready` rises. For each warp, a plain `fetch_ok` pin tells the fetch stage that the warp's queue is empty, which is the only condition under which fetch for that warp may proceed.

The issue stage reads the per-slot ready flags. It takes the head instruction of a warp by pulsing that warp's bit of `iss_take`. Writebacks return one register per cycle. A per-warp flush discards queued instructions and leaves in-flight reservations in place.

Top module: `warp_issue_buffer`

## Requirements
- R1: After reset, no slot is valid or ready, every `fetch_ok` bit is 1, and no register of any warp is reserved.
- R2: `fetch_ok[w]` is 1 exactly when warp w holds no valid instruction.
- R3: `in_ready` is 1 when warp `in_warp` has a free slot and `flush[in_warp]` is 0. An accepted instruction takes the lowest free slot of its warp, so slot 0 always holds the oldest one. When the warp is full, the offered instruction is not stored.
- R4: Slot 0 of a warp is ready when it is valid and neither its destination nor any of its sources is reserved for that warp. The flags appear in `slot_rdy[w*SLOTS+k]`, and the sources are packed with source s in `in_src[s*RW +: RW]`.
- R5: A slot k>0 is ready only when slot k-1 is ready and the slot's own registers are neither reserved nor equal to the destination of any older slot of the same warp.
- R6: A pulse on `iss_take[w]` while slot 0 of warp w is ready removes that instruction and shifts the younger ones down. It also reserves that instruction's destination from the next cycle on. A pulse while slot 0 is not ready has no effect.
- R7: A writeback (`wb_valid`, `wb_warp`, `wb_reg`) releases the register for that warp from the next cycle on, so a waiting instruction becomes ready one cycle after the writeback.
- R8: When a writeback releases and an issue reserves the same register of the same warp in one cycle, the register stays reserved.
- R9: `flush[w]` empties warp w's queue on the next edge. It ignores an issue pulse and an input offered to w in that cycle, and leaves all reservations unchanged.
- R10: Reservations are kept per warp. A register reserved in one warp does not hold back an instruction of another warp that names the same register number.
- R11: Reservations from several issued instructions of one warp accumulate. Each one is released only by its own writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle if valid |
| in_warp | input | WW | Warp of the offered instruction |
| in_dst | input | RW | Destination register |
| in_src | input | SRCS*RW | Source registers, source s at bits s*RW |
| fetch_ok | output | WARPS | Per-warp fetch permission (queue empty) |
| slot_vld | output | WARPS*SLOTS | Per-slot valid flags |
| slot_rdy | output | WARPS*SLOTS | Per-slot hazard-free ready flags |
| iss_take | input | WARPS | Issue head instruction of warp |
| wb_valid | input | 1 | Writeback of one register |
| wb_warp | input | WW | Warp of the writeback |
| wb_reg | input | RW | Register released |
| flush | input | WARPS | Per-warp queue flush |

## Verification
Two sets of events can land on the same clock edge. The first is a writeback releasing a register while an issue of the same warp reserves that same register. The second is a flush of a warp while an issue pulse for it arrives. The bench drives each pair in one cycle. It then queues an instruction that reads the register in question and judges the outcome from that instruction's ready flag. The flag must stay low after the release-and-reserve collision. It must rise at once after the flush-and-issue collision, because the flushed instruction never reserved anything. A third coincidence, a pop and a push to the same warp on one edge, is judged by the new head's ready flag.

// File: rtl/ibsb_pkg.sv
package ibsb_pkg;
  localparam int DEF_WARPS = 4;
  localparam int DEF_SLOTS = 2;
  localparam int DEF_REGS  = 16;
  localparam int DEF_SRCS  = 2;
endpackage

// File: rtl/ibsb_resv_table.sv
module ibsb_resv_table #(
  parameter int WARPS = ibsb_pkg::DEF_WARPS,
  parameter int REGS  = ibsb_pkg::DEF_REGS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [WARPS*REGS-1:0]  set_vec,
  input  logic [WARPS*REGS-1:0]  clr_vec,
  output logic [WARPS*REGS-1:0]  resv
);
  localparam int BITS = WARPS * REGS;

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resv <= '0;
    else        resv <= (resv & ~clr_vec) | set_vec;
  end

  for (genvar i = 0; i < BITS; i++) begin : g_chk
    assert_reserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> resv[i]);
    assert_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (resv[i] && !clr_vec[i]) |=> resv[i]);
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !resv[i]);
  end
endmodule

// File: rtl/ibsb_warp_queue.sv
module ibsb_warp_queue #(
  parameter int SLOTS = ibsb_pkg::DEF_SLOTS,
  parameter int REGS  = ibsb_pkg::DEF_REGS,
  parameter int SRCS  = ibsb_pkg::DEF_SRCS,
  localparam int RW   = $clog2(REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [RW-1:0]      push_dst,
  input  logic [SRCS*RW-1:0] push_src,
  input  logic               pop,
  input  logic               flush,
  input  logic [REGS-1:0]    resv,
  output logic [SLOTS-1:0]   vld,
  output logic [SLOTS-1:0]   rdy,
  output logic [RW-1:0]      head_dst,
  output logic               full,
  output logic               empty
);
  logic [RW-1:0]      dst_q [SLOTS];
  logic [SRCS*RW-1:0] src_q [SLOTS];
  logic [SLOTS-1:0]   n_vld;
  logic [RW-1:0]      n_dst [SLOTS];
  logic [SRCS*RW-1:0] n_src [SLOTS];

  // next state: optional shift by one, then append at first free slot
  always_comb begin
    logic placed;
    for (int k = 0; k < SLOTS; k++) begin
      if (pop) begin
        n_vld[k] = (k < SLOTS - 1) ? vld[(k + 1) % SLOTS] : 1'b0;
        n_dst[k] = dst_q[(k + 1) % SLOTS];
        n_src[k] = src_q[(k + 1) % SLOTS];
      end else begin
        n_vld[k] = vld[k];
        n_dst[k] = dst_q[k];
        n_src[k] = src_q[k];
      end
    end
    placed = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (push && !placed && !n_vld[k]) begin
        n_vld[k] = 1'b1;
        n_dst[k] = push_dst;
        n_src[k] = push_src;
        placed   = 1'b1;
      end
    end
    if (flush) n_vld = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int k = 0; k < SLOTS; k++) begin
        dst_q[k] <= '0;
        src_q[k] <= '0;
      end
    end else begin
      vld <= n_vld;
      for (int k = 0; k < SLOTS; k++) begin
        dst_q[k] <= n_dst[k];
        src_q[k] <= n_src[k];
      end
    end
  end

  // hazard check: reserved set (RAW/WAW) plus older slots' destinations
  always_comb begin
    logic prev_ok;
    logic hz;
    prev_ok = 1'b1;
    for (int k = 0; k < SLOTS; k++) begin
      hz = resv[dst_q[k]];
      for (int s = 0; s < SRCS; s++)
        hz = hz | resv[src_q[k][s*RW +: RW]];
      for (int j = 0; j < SLOTS; j++) begin
        if (j < k) begin
          hz = hz | (dst_q[j] == dst_q[k]);
          for (int s = 0; s < SRCS; s++)
            hz = hz | (dst_q[j] == src_q[k][s*RW +: RW]);
        end
      end
      rdy[k]  = vld[k] & ~hz & prev_ok;
      prev_ok = rdy[k];
    end
  end

  assign head_dst = dst_q[0];
  assign full     = &vld;
  assign empty    = ~|vld;

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !flush) |=> ($countones(vld) >= $past($countones(vld))));
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));
  assert_grow_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(vld) <= $past($countones(vld)) + 1));
endmodule

// File: rtl/warp_issue_buffer.sv
module warp_issue_buffer #(
  parameter int WARPS = ibsb_pkg::DEF_WARPS,
  parameter int SLOTS = ibsb_pkg::DEF_SLOTS,
  parameter int REGS  = ibsb_pkg::DEF_REGS,
  parameter int SRCS  = ibsb_pkg::DEF_SRCS,
  localparam int WW   = $clog2(WARPS),
  localparam int RW   = $clog2(REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [WW-1:0]          in_warp,
  input  logic [RW-1:0]          in_dst,
  input  logic [SRCS*RW-1:0]     in_src,
  output logic [WARPS-1:0]       fetch_ok,
  output logic [WARPS*SLOTS-1:0] slot_vld,
  output logic [WARPS*SLOTS-1:0] slot_rdy,
  input  logic [WARPS-1:0]       iss_take,
  input  logic                   wb_valid,
  input  logic [WW-1:0]          wb_warp,
  input  logic [RW-1:0]          wb_reg,
  input  logic [WARPS-1:0]       flush
);
  logic [WARPS-1:0]      full;
  logic [WARPS-1:0]      pop;
  logic [WARPS*REGS-1:0] set_vec;
  logic [WARPS*REGS-1:0] clr_vec;
  logic [WARPS*REGS-1:0] resv;
  logic [RW-1:0]         head_dst [WARPS];

  always_comb begin
    in_ready = 1'b0;
    for (int w = 0; w < WARPS; w++)
      if (in_warp == WW'(w)) in_ready = ~full[w] & ~flush[w];
  end

  for (genvar w = 0; w < WARPS; w++) begin : g_warp
    logic push_w;
    assign push_w = in_valid & in_ready & (in_warp == WW'(w));
    assign pop[w] = iss_take[w] & slot_rdy[w*SLOTS] & ~flush[w];
    assign set_vec[w*REGS +: REGS] = pop[w] ? (REGS'(1) << head_dst[w]) : '0;
    assign clr_vec[w*REGS +: REGS] = (wb_valid && wb_warp == WW'(w))
                                     ? (REGS'(1) << wb_reg) : '0;

    ibsb_warp_queue #(.SLOTS(SLOTS), .REGS(REGS), .SRCS(SRCS)) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push_w),
      .push_dst (in_dst),
      .push_src (in_src),
      .pop      (pop[w]),
      .flush    (flush[w]),
      .resv     (resv[w*REGS +: REGS]),
      .vld      (slot_vld[w*SLOTS +: SLOTS]),
      .rdy      (slot_rdy[w*SLOTS +: SLOTS]),
      .head_dst (head_dst[w]),
      .full     (full[w]),
      .empty    (fetch_ok[w])
    );

    assert_fetch_after_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flush[w] |=> fetch_ok[w]);
    assert_issue_reserves_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pop[w] |=> resv[w*REGS + int'($past(head_dst[w]))]);
  end

  ibsb_resv_table #(.WARPS(WARPS), .REGS(REGS)) u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .resv    (resv)
  );
endmodule

// File: tb/warp_issue_buffer_tb.sv
module warp_issue_buffer_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 28;

  typedef struct packed {
    logic       push;
    logic [1:0] w;
    logic [3:0] d;
    logic [3:0] s0;
    logic [3:0] s1;
    logic [3:0] take;
    logic       wb;
    logic [1:0] wbw;
    logic [3:0] wbr;
    logic [3:0] fl;
    logic       ir;
    logic [7:0] rdy;
    logic [3:0] fok;
  } vec_t;

  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1,2'd0,4'd1,4'd2,4'd3,   4'h0,1'b0,2'd0,4'd0,4'h0,1'b1,8'h01,4'hE},
    '{1'b1,2'd0,4'd4,4'd1,4'd5,   4'h0,1'b0,2'd0,4'd0,4'h0,1'b1,8'h01,4'hE},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h1,1'b0,2'd0,4'd0,4'h0,1'b0,8'h00,4'hE},
    '{1'b1,2'd1,4'd1,4'd1,4'd1,   4'h0,1'b0,2'd0,4'd0,4'h0,1'b1,8'h04,4'hC},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h0,1'b1,2'd0,4'd1,4'h0,1'b0,8'h05,4'hC},
    '{1'b1,2'd0,4'd4,4'd0,4'd0,   4'h1,1'b0,2'd0,4'd0,4'h0,1'b1,8'h04,4'hC},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h2,1'b1,2'd0,4'd4,4'h0,1'b0,8'h01,4'hE},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h1,1'b1,2'd0,4'd4,4'h0,1'b0,8'h00,4'hF},
    '{1'b1,2'd0,4'd6,4'd4,4'd7,   4'h0,1'b0,2'd0,4'd0,4'h0,1'b1,8'h00,4'hE},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h0,1'b0,2'd0,4'd0,4'h1,1'b0,8'h00,4'hF},
    '{1'b1,2'd0,4'd8,4'd4,4'd9,   4'h0,1'b0,2'd0,4'd0,4'h0,1'b1,8'h00,4'hE},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h0,1'b1,2'd0,4'd4,4'h0,1'b0,8'h01,4'hE},
    '{1'b1,2'd0,4'd10,4'd11,4'd12,4'h0,1'b0,2'd0,4'd0,4'h0,1'b1,8'h03,4'hE},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h1,1'b0,2'd0,4'd0,4'h0,1'b0,8'h01,4'hE},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h1,1'b0,2'd0,4'd0,4'h0,1'b0,8'h00,4'hF},
    '{1'b1,2'd0,4'd3,4'd8,4'd0,   4'h0,1'b0,2'd0,4'd0,4'h0,1'b1,8'h00,4'hE},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h0,1'b1,2'd0,4'd10,4'h0,1'b0,8'h00,4'hE},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h0,1'b1,2'd0,4'd8,4'h0,1'b0,8'h01,4'hE},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h1,1'b0,2'd0,4'd0,4'h1,1'b0,8'h00,4'hF},
    '{1'b1,2'd0,4'd5,4'd3,4'd3,   4'h0,1'b0,2'd0,4'd0,4'h0,1'b1,8'h01,4'hE},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h1,1'b0,2'd0,4'd0,4'h0,1'b0,8'h00,4'hF},
    '{1'b1,2'd2,4'd5,4'd5,4'd5,   4'h0,1'b0,2'd0,4'd0,4'h0,1'b1,8'h10,4'hB},
    '{1'b1,2'd0,4'd7,4'd5,4'd0,   4'h0,1'b0,2'd0,4'd0,4'h0,1'b1,8'h10,4'hA},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h1,1'b0,2'd0,4'd0,4'h0,1'b0,8'h10,4'hA},
    '{1'b1,2'd2,4'd9,4'd1,4'd2,   4'h0,1'b0,2'd0,4'd0,4'h0,1'b1,8'h30,4'hA},
    '{1'b1,2'd2,4'd5,4'd0,4'd0,   4'h0,1'b0,2'd0,4'd0,4'h0,1'b0,8'h30,4'hA},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h4,1'b0,2'd0,4'd0,4'h0,1'b0,8'h10,4'hA},
    '{1'b0,2'd0,4'd0,4'd0,4'd0,   4'h4,1'b0,2'd0,4'd0,4'h0,1'b0,8'h00,4'hE}
  };

  localparam string TAG [0:NV-1] = '{
    "R3","R5","R6","R10","R7","R6","R7","R8","R8","R9",
    "R9","R7","R5","R6","R11","R11","R11","R7","R9","R9",
    "R6","R10","R4","R6","R5","R3","R3","R3"};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_warp = '0;
  logic [3:0] in_dst = '0;
  logic [7:0] in_src = '0;
  logic [3:0] fetch_ok;
  logic [7:0] slot_vld;
  logic [7:0] slot_rdy;
  logic [3:0] iss_take = '0;
  logic       wb_valid = 1'b0;
  logic [1:0] wb_warp = '0;
  logic [3:0] wb_reg = '0;
  logic [3:0] flush = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  warp_issue_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_warp(in_warp), .in_dst(in_dst), .in_src(in_src), .fetch_ok(fetch_ok),
    .slot_vld(slot_vld), .slot_rdy(slot_rdy), .iss_take(iss_take),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg), .flush(flush)
  );

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0; iss_take = '0; wb_valid = 1'b0; flush = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "slot_rdy at reset", slot_rdy, 8'h00);
    check("R1", "slot_vld at reset", slot_vld, 8'h00);
    check("R1", "fetch_ok at reset", {4'h0, fetch_ok}, 8'h0F);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      in_valid = VEC[i].push;
      in_warp  = VEC[i].w;
      in_dst   = VEC[i].d;
      in_src   = {VEC[i].s1, VEC[i].s0};
      iss_take = VEC[i].take;
      wb_valid = VEC[i].wb;
      wb_warp  = VEC[i].wbw;
      wb_reg   = VEC[i].wbr;
      flush    = VEC[i].fl;
      #1;
      if (VEC[i].push) check("R3", "in_ready", {7'h0, in_ready}, {7'h0, VEC[i].ir});
      @(negedge clk);
      idle();
      check(TAG[i], $sformatf("slot_rdy row %0d", i), slot_rdy, VEC[i].rdy);
      check("R2", $sformatf("fetch_ok row %0d", i), {4'h0, fetch_ok}, {4'h0, VEC[i].fok});
    end

    // R3: w0 holds one instruction, w2 empty
    check("R3", "slot_vld after table", slot_vld, 8'h01);

    // R9: flush blocks input to that warp in the same cycle
    in_valid = 1'b1; in_warp = 2'd3; in_dst = 4'd1; in_src = 8'h00; flush = 4'h8;
    #1;
    check("R9", "in_ready under flush", {7'h0, in_ready}, 8'h00);
    @(negedge clk);
    idle();
    check("R9", "flushed warp stays empty", {4'h0, fetch_ok}, 8'h0E);

    // R1: mid-run reset clears queues and reservations (w2 holds 5 and 9)
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "slot_vld after reset", slot_vld, 8'h00);
    check("R1", "fetch_ok after reset", {4'h0, fetch_ok}, 8'h0F);
    rst_n = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_warp = 2'd2; in_dst = 4'd5; in_src = {4'd9, 4'd5};
    @(negedge clk);
    idle();
    check("R1", "no reservation after reset", slot_rdy, 8'h10);
    check("R3", "slot_vld after push", slot_vld, 8'h10);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule